// File: doc/BRIEF.md
# Serial DAC command input interface

This block is the digital front end of a 12-bit voltage-output converter. It receives a three-wire serial stream: an active-low select, a serial clock and a data line. All three are synchronised into the core clock domain. Each falling edge of the serial clock that occurs inside a select frame shifts one bit into a 16-bit register, most significant bit first. An edge counter commits the word on its 16th edge, with no further action by the sender. The committed word goes into an input latch. Its top four bits are then decoded as a command.

The only active command is code 0000. It copies the 12-bit data field from the latch into the converter code register, which drives the analog stage, and raises a one-cycle update strobe. Every other code is a no-op. Once a word is committed, further serial clock edges in the same frame are locked out. Select must return high and then fall again before the next word is accepted. While select is high, the serial clock has no effect.

The update strobe is a valid indication with no ready. The block applies no back-pressure, and a downstream consumer must take the code in the cycle the strobe is high.

Top module: `dacif_top`

## Requirements
- R1: After reset, dac_code is 0 and dac_upd is low.
- R2: A word is 16 bits taken on serial clock falling edges, first bit received as bit 15. Bits [15:12] are the command and bits [11:0] are the data.
- R3: A committed word with command 0000 sets dac_code to its data field and pulses dac_upd high for exactly one clock cycle. dac_code changes only in that cycle.
- R4: A committed word with any command other than 0000 leaves dac_code unchanged and raises no dac_upd.
- R5: Serial clock edges after the 16th in the same select-low frame are ignored. Only the first word of the frame is acted on.
- R6: A frame that ends, with select going high, before 16 edges has no effect. The next frame starts again at bit 15.
- R7: Serial clock edges while select is high have no effect on dac_code or dac_upd, and do not shift into the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| sdi | input | 1 | Serial data |
| dac_code | output | 12 | Converter code register |
| dac_upd | output | 1 | One-cycle strobe when dac_code is written |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 4-bit command field, a 12-bit data field and two synchroniser stages. Every one of the 16 command codes is applied, each with several data values. The data field is swept with a stride that reaches both end codes and many values between them. The cases this configuration makes small enough to cover directly are also applied: frames with extra clocks, frames aborted at every bit count, and serial clocks toggled with select high.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  typedef enum logic [3:0] {
    CMD_LOAD = 4'h0
  } cmd_e;

  function automatic logic cmd_is_load(input logic [3:0] c);
    return c == CMD_LOAD;
  endfunction
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else     chain[i] <= chain[i-1];
    end
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/dacif_shift.sv
module dacif_shift #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  cnt,
  output logic              locked
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_q;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shnext;
  logic              fall;

  assign fall   = sclk_q & ~sclk_s;
  assign shnext = {shreg[WORD_W-2:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      shreg    <= '0;
      word     <= '0;
      word_vld <= 1'b0;
      cnt      <= '0;
      locked   <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      word_vld <= 1'b0;
      if (!cs_act) begin
        cnt    <= '0;
        locked <= 1'b0;
      end else if (fall && !locked) begin
        shreg <= shnext;
        if (cnt == LAST) begin
          word     <= shnext;
          word_vld <= 1'b1;
          locked   <= 1'b1;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dacif_load.sv
module dacif_load
  import dacif_pkg::*;
#(
  parameter int CMD_W = 4,
  parameter int DATA_W = 12,
  localparam int WORD_W = CMD_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  output logic              lat_vld,
  output logic [CMD_W-1:0]  lat_cmd,
  output logic [DATA_W-1:0] dac_code,
  output logic              dac_upd
);
  logic [WORD_W-1:0] in_lat;

  assign lat_cmd = in_lat[WORD_W-1 -: CMD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      in_lat   <= '0;
      lat_vld  <= 1'b0;
      dac_code <= '0;
      dac_upd  <= 1'b0;
    end else begin
      lat_vld <= word_vld;
      dac_upd <= 1'b0;
      if (word_vld) in_lat <= word;
      if (lat_vld && cmd_is_load(4'(lat_cmd))) begin
        dac_code <= in_lat[DATA_W-1:0];
        dac_upd  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dacif_top.sv
module dacif_top #(
  parameter int CMD_W = 4,
  parameter int DATA_W = 12,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W = CMD_W + DATA_W,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic [DATA_W-1:0] dac_code,
  output logic              dac_upd
);
  logic [2:0]        pins_s;
  logic              cs_act;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  cnt;
  logic              locked;
  logic              lat_vld;
  logic [CMD_W-1:0]  lat_cmd;

  dacif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d_in({cs_n, sclk, sdi}), .d_out(pins_s)
  );

  assign cs_act = ~pins_s[2];

  dacif_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_s(pins_s[1]),
    .sdi_s(pins_s[0]), .word_vld(word_vld), .word(word),
    .cnt(cnt), .locked(locked)
  );

  dacif_load #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_load (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word(word),
    .lat_vld(lat_vld), .lat_cmd(lat_cmd),
    .dac_code(dac_code), .dac_upd(dac_upd)
  );
endmodule

// File: rtl/dacif_chk.sv
module dacif_chk #(
  parameter int CMD_W = 4,
  parameter int DATA_W = 12,
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_act,
  input logic [CNT_W-1:0]  cnt,
  input logic              locked,
  input logic              word_vld,
  input logic              lat_vld,
  input logic [CMD_W-1:0]  lat_cmd,
  input logic [DATA_W-1:0] dac_code,
  input logic              dac_upd
);
  // R3: the strobe lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    dac_upd |=> !dac_upd);
  // R3: the code register moves only with the strobe
  a_r3_code_with_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> dac_upd);
  // R4: a strobe follows only a latched load command
  a_r4_load_only: assert property (@(posedge clk) disable iff (rst)
    dac_upd |-> ($past(lat_vld) && $past(lat_cmd) == '0));
  // R5: no second commit while locked
  a_r5_locked_no_commit: assert property (@(posedge clk) disable iff (rst)
    ($past(locked) && locked) |-> !word_vld);
  // R6, R7: select high clears the counter and the lock
  a_r7_idle_clears: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (cnt == '0 && !locked));
endmodule

bind dacif_top dacif_chk #(.CMD_W(CMD_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .cnt(cnt), .locked(locked),
  .word_vld(word_vld), .lat_vld(lat_vld), .lat_cmd(lat_cmd),
  .dac_code(dac_code), .dac_upd(dac_upd)
);

// File: tb/dacif_top_tb.sv
module dacif_top_tb;
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [11:0] dac_code;
  logic dac_upd;

  int vecs = 0;
  int errs = 0;
  int upd_cnt = 0;
  logic [11:0] exp_code = '0;
  int exp_upd = 0;

  always #4 clk = ~clk;

  dacif_top u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .dac_code(dac_code), .dac_upd(dac_upd)
  );

  always @(posedge clk) if (!rst && dac_upd) upd_cnt <= upd_cnt + 1;

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    sdi = b;
    sclk = 1'b1;
    wait_cyc(PH);
    sclk = 1'b0;
    wait_cyc(PH);
  endtask

  // Shift nbits of w, MSB first, starting at bit 15 of a 16-bit word.
  task automatic shift_bits(input logic [15:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) clk_bit(w[15 - (i % 16)]);
  endtask

  task automatic frame_open();
    cs_n = 1'b0;
    wait_cyc(PH);
  endtask

  task automatic frame_close();
    cs_n = 1'b1;
    wait_cyc(3 * PH);
  endtask

  task automatic check(input string req, input logic [11:0] code, input int upd);
    vecs++;
    if (dac_code !== code || upd_cnt !== upd) begin
      errs++;
      $display("FAIL %s: dac_code=%h upd=%0d expected dac_code=%h upd=%0d",
               req, dac_code, upd_cnt, code, upd);
    end
  endtask

  task automatic model(input logic [15:0] w);
    if (w[15:12] == 4'h0) begin
      exp_code = w[11:0];
      exp_upd++;
    end
  endtask

  task automatic send_word(input logic [15:0] w, input string req);
    frame_open();
    shift_bits(w, 16);
    frame_close();
    model(w);
    check(req, exp_code, exp_upd);
  endtask

  initial begin
    wait_cyc(5);
    // R1: reset state
    vecs++;
    if (dac_code !== 12'h000 || dac_upd !== 1'b0) begin
      errs++;
      $display("FAIL R1: dac_code=%h dac_upd=%b expected 000 0", dac_code, dac_upd);
    end
    rst = 1'b0;
    wait_cyc(4);
    check("R1", 12'h000, 0);

    // R2, R3: stride sweep over the data field with load command
    for (int d = 0; d < 4096; d += 37) send_word({4'h0, 12'(d)}, "R3");
    send_word(16'h0FFF, "R2");
    send_word(16'h0800, "R2");
    send_word(16'h0001, "R2");

    // R4: every non-load command with several data values
    for (int c = 1; c < 16; c++) begin
      send_word({4'(c), 12'hA5A}, "R4");
      send_word({4'(c), 12'h000}, "R4");
      send_word({4'h0, 12'(c * 211)}, "R3");
    end

    // R5: extra clocks after the 16th in one frame
    for (int k = 1; k <= 16; k++) begin
      frame_open();
      shift_bits({4'h0, 12'(k * 97)}, 16);
      shift_bits({4'h0, 12'hF0F}, k);
      frame_close();
      model({4'h0, 12'(k * 97)});
      check("R5", exp_code, exp_upd);
    end

    // R6: aborted frames at every short length, then a full word
    for (int n = 1; n < 16; n++) begin
      frame_open();
      shift_bits({4'h0, 12'hC3C}, n);
      frame_close();
      check("R6", exp_code, exp_upd);
      send_word({4'h0, 12'(n * 173)}, "R6");
    end

    // R7: serial clocks with select high
    for (int n = 1; n <= 20; n += 3) begin
      for (int i = 0; i < n; i++) clk_bit(i[0]);
      wait_cyc(3 * PH);
      check("R7", exp_code, exp_upd);
      frame_open();
      shift_bits({4'h0, 12'(n * 59)}, 10);
      for (int i = 0; i < 5; i++) begin
        cs_n = 1'b1;
        clk_bit(1'b1);
        cs_n = 1'b0;
        wait_cyc(PH);
      end
      frame_close();
      check("R7", exp_code, exp_upd);
      send_word({4'h0, 12'(n * 59)}, "R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    vecs++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule